// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the front of a receive path and decides, once per frame, whether the frame should be kept based on its 48-bit destination address. The address arrives one byte per clock on a byte strobe, with the first byte of each frame flagged by a start marker. The block assembles the six address bytes and runs the Ethernet CRC-32 over them as they arrive. One clock after the sixth byte it emits a single-cycle verdict.

The filter recognises four cases, in falling priority. Promiscuous mode keeps everything. Broadcast is kept only when broadcast acceptance is enabled. A group (multicast) address is kept when all-multicast is enabled, or else when a 64-entry hash table has the bit selected by the address's CRC. A unicast address is kept only when it equals the programmed station address.

The station address and the hash table are static configuration inputs. Frame content after the sixth byte is not examined.

Top module: `rx_dest_filter`

## Requirements
- R1: A frame starts with a byte that has both `byte_valid` and `byte_sof` high; valid bytes that arrive while no frame is open (after reset, or after a frame's sixth byte) are ignored and produce no verdict.
- R2: `verdict_valid` is high for exactly one cycle, in the cycle after the clock edge that takes a frame's sixth byte; `verdict_accept` is low whenever `verdict_valid` is low.
- R3: Bytes after the sixth are ignored until the next start byte; a start byte seen part-way through an address discards the partial address and begins a new one; gaps with `byte_valid` low between bytes are allowed.
- R4: When `mode_cfg[3]` (promiscuous) is 1, every frame is accepted, including broadcast and group addresses.
- R5: Without promiscuous mode, the all-ones address is accepted exactly when `mode_cfg[0]` is 1, whatever the other mode bits are.
- R6: Without promiscuous mode, a group address (bit 0 of byte 0 set, not all ones) is accepted when `mode_cfg[2]` (all-multicast) is 1, regardless of the hash table.
- R7: With `mode_cfg[3:2]` = 0 and `mode_cfg[1]` = 1, a group address is accepted exactly when bit k of the table is set, where k is bits 28:23 of a CRC-32 (polynomial 0x04C11DB7, left-shifting register, initial value all ones, no final inversion) fed with the six address bytes in arrival order, each byte least significant bit first; k[5]=1 selects `hash_hi`, k[5]=0 selects `hash_lo`, and k[4:0] selects the bit.
- R8: A group address with `mode_cfg[3:1]` = 0 is rejected.
- R9: Without promiscuous mode, a unicast address (bit 0 of byte 0 clear) is accepted exactly when all six bytes equal the station address, where byte 0 (first received) is `station_w2[7:0]`, byte 1 is `station_w2[15:8]`, bytes 2 and 3 are `station_w1[7:0]` and `[15:8]`, and bytes 4 and 5 are `station_w0[7:0]` and `[15:8]`.
- R10: While `rst_n` is low at a clock edge, both outputs are 0 after that edge and any partial address is discarded.
- R11: The verdict uses the configuration inputs present at the clock edge that takes the sixth byte; a change in the following cycle does not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | Address byte strobe |
| byte_sof | input | 1 | Marks the first byte of a frame (used with byte_valid) |
| byte_data | input | 8 | Address byte |
| mode_cfg | input | 4 | [0] broadcast, [1] hashed group, [2] all group, [3] promiscuous |
| station_w0 | input | 16 | Station address bytes 4 (low) and 5 (high) |
| station_w1 | input | 16 | Station address bytes 2 (low) and 3 (high) |
| station_w2 | input | 16 | Station address bytes 0 (low) and 1 (high) |
| hash_lo | input | 32 | Hash table entries 0..31 |
| hash_hi | input | 32 | Hash table entries 32..63 |
| verdict_valid | output | 1 | One-cycle pulse carrying the frame decision |
| verdict_accept | output | 1 | 1 = keep frame, valid with verdict_valid |

## Verification
Unicast traffic is tried with an exact station match and with single-bit differences in the first and last bytes, which separates a full 48-bit compare from a partial one and checks the byte-to-register mapping. Broadcast and group addresses are sent under each mode combination, so that priority mistakes (broadcast treated as group, all-multicast overriding promiscuous) show up as wrong verdicts. Hashed group addresses are chosen in the bench so that one lands in each table word, and the table is set to a lone one or a lone zero at that index, which distinguishes a correct CRC index and word select from any neighbouring bit. Streams with gaps, trailing bytes, restarts mid-address, stray bytes with no start marker and a configuration change right after the sixth byte probe the framing and the sampling point.

// File: rtl/rxaf_pkg.sv
// Shared types and the CRC step used by the receive destination filter.
// Assumes a six-byte address with byte 0 received first.
package rxaf_pkg;
    parameter int MAC_BYTES = 6;
    parameter logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    parameter logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    // Byte i of the address sits at index i.
    typedef logic [MAC_BYTES-1:0][7:0] mac_t;

    // Advance the left-shifting CRC register by one byte, LSB first.
    function automatic logic [31:0] crc_update(input logic [31:0] seed,
                                               input logic [7:0]  data);
        logic [31:0] r;
        r = seed;
        for (int b = 0; b < 8; b++) begin
            if (r[31] ^ data[b]) r = (r << 1) ^ CRC_POLY;
            else                 r = r << 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/rxaf_collect.sv
// Address collector: counts the first MAC_BYTES bytes of a frame, stores
// them, and runs the CRC alongside. Presents the complete address, the
// hash index and a last-byte flag in the cycle the final byte arrives.
// Assumes byte_sof is only meaningful together with byte_valid.
module rxaf_collect
    import rxaf_pkg::*;
#(
    parameter int HASH_LSB   = 23,
    parameter int HASH_IDX_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  byte_valid,
    input  logic                  byte_sof,
    input  logic [7:0]            byte_data,
    output logic                  addr_last,
    output mac_t                  addr_now,
    output logic [HASH_IDX_W-1:0] hash_idx
);
    localparam int CW = $clog2(MAC_BYTES + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] slot;
    logic          take_first;
    logic          take_next;
    logic          take;
    logic [31:0]   crc_q;
    logic [31:0]   crc_seed;
    logic [31:0]   crc_now;
    mac_t          addr_q;

    // Decide whether this byte belongs to an address and where it goes.
    always_comb begin
        take_first = byte_valid && byte_sof;
        take_next  = byte_valid && !byte_sof && (cnt_q != '0)
                     && (cnt_q < CW'(MAC_BYTES));
        take       = take_first || take_next;
        slot       = take_first ? '0 : cnt_q;
        crc_seed   = take_first ? CRC_INIT : crc_q;
        crc_now    = crc_update(crc_seed, byte_data);
        addr_last  = take && (slot == CW'(MAC_BYTES - 1));
        hash_idx   = crc_now[HASH_LSB +: HASH_IDX_W];
    end

    // Merge the incoming byte into the stored address, one lane per byte.
    for (genvar i = 0; i < MAC_BYTES; i++) begin : g_lane
        assign addr_now[i] = (take && slot == CW'(i)) ? byte_data : addr_q[i];
    end

    // Hold byte count, partial address and running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            crc_q  <= CRC_INIT;
            addr_q <= '0;
        end else if (take) begin
            cnt_q  <= slot + CW'(1);
            crc_q  <= crc_now;
            addr_q <= addr_now;
        end
    end
endmodule

// File: rtl/rxaf_hash.sv
// Hash table lookup: the top index bit picks the table word, the rest
// pick the bit inside it. Assumes the table word width is 2**(IDX_W-1).
module rxaf_hash #(
    parameter int IDX_W = 6,
    localparam int WORD_W = 1 << (IDX_W - 1)
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] tbl_lo,
    input  logic [WORD_W-1:0] tbl_hi,
    output logic              hit
);
    logic [WORD_W-1:0] word_sel;

    // Select the word, then the bit.
    always_comb begin
        word_sel = idx[IDX_W-1] ? tbl_hi : tbl_lo;
        hit      = word_sel[idx[IDX_W-2:0]];
    end
endmodule

// File: rtl/rxaf_decide.sv
// Accept/reject decision for a complete address under the mode bits.
// Priority: promiscuous, then broadcast, then group (all, then hashed),
// then unicast exact match. Purely combinational.
module rxaf_decide
    import rxaf_pkg::*;
(
    input  mac_t       dst,
    input  mac_t       stn,
    input  logic [3:0] mode,
    input  logic       hash_hit,
    output logic       accept
);
    logic is_bcast;
    logic is_group;

    // Classify the address and apply the priority chain.
    always_comb begin
        is_bcast = &dst;
        is_group = dst[0][0];
        if (mode[3])       accept = 1'b1;
        else if (is_bcast) accept = mode[0];
        else if (is_group) accept = mode[2] || (mode[1] && hash_hit);
        else               accept = (dst == stn);
    end
endmodule

// File: rtl/rx_dest_filter.sv
// Receive destination address filter, top level. Collects the address,
// looks up the hash table, decides, and registers a one-cycle verdict.
// Assumes configuration inputs are quasi-static relative to frames.
module rx_dest_filter
    import rxaf_pkg::*;
#(
    parameter int HASH_LSB   = 23,
    parameter int HASH_IDX_W = 6,
    localparam int HWORD_W   = 1 << (HASH_IDX_W - 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_valid,
    input  logic               byte_sof,
    input  logic [7:0]         byte_data,
    input  logic [3:0]         mode_cfg,
    input  logic [15:0]        station_w0,
    input  logic [15:0]        station_w1,
    input  logic [15:0]        station_w2,
    input  logic [HWORD_W-1:0] hash_lo,
    input  logic [HWORD_W-1:0] hash_hi,
    output logic               verdict_valid,
    output logic               verdict_accept
);
    logic                  addr_last;
    mac_t                  addr_now;
    mac_t                  stn_addr;
    logic [HASH_IDX_W-1:0] hash_idx;
    logic                  hash_hit;
    logic                  accept_now;

    // Station register words map to bytes 5..0 from most to least significant.
    assign stn_addr = {station_w0, station_w1, station_w2};

    rxaf_collect #(.HASH_LSB(HASH_LSB), .HASH_IDX_W(HASH_IDX_W)) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_sof   (byte_sof),
        .byte_data  (byte_data),
        .addr_last  (addr_last),
        .addr_now   (addr_now),
        .hash_idx   (hash_idx)
    );

    rxaf_hash #(.IDX_W(HASH_IDX_W)) u_hash (
        .idx    (hash_idx),
        .tbl_lo (hash_lo),
        .tbl_hi (hash_hi),
        .hit    (hash_hit)
    );

    rxaf_decide u_decide (
        .dst      (addr_now),
        .stn      (stn_addr),
        .mode     (mode_cfg),
        .hash_hit (hash_hit),
        .accept   (accept_now)
    );

    // Register the verdict one clock after the last address byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_valid  <= 1'b0;
            verdict_accept <= 1'b0;
        end else begin
            verdict_valid  <= addr_last;
            verdict_accept <= addr_last && accept_now;
        end
    end
endmodule

// File: rtl/rxaf_chk.sv
// Property checker for rx_dest_filter, attached by bind.
// Observes the last-byte flag and assembled address from the collector.
module rxaf_chk
    import rxaf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       byte_valid,
    input logic [3:0] mode_cfg,
    input logic       frame_last,
    input mac_t       dst_addr,
    input mac_t       stn_addr,
    input logic       verdict_valid,
    input logic       verdict_accept
);
    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid);
    // R2
    idle_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !verdict_valid |-> !verdict_accept);
    // R2
    verdict_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |=> verdict_valid);
    // R1
    byte_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |-> byte_valid);
    // R4
    promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_last && mode_cfg[3]) |=> verdict_accept);
    // R5
    bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_last && !mode_cfg[3] && (dst_addr == '1))
        |=> (verdict_accept == $past(mode_cfg[0])));
    // R6
    allgroup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_last && !mode_cfg[3] && mode_cfg[2] && dst_addr[0][0]
         && (dst_addr != '1)) |=> verdict_accept);
    // R8
    group_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_last && (mode_cfg[3:1] == 3'b000) && dst_addr[0][0]
         && (dst_addr != '1)) |=> !verdict_accept);
    // R9
    ucast_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_last && !mode_cfg[3] && !dst_addr[0][0]
         && (dst_addr != stn_addr)) |=> !verdict_accept);
endmodule

bind rx_dest_filter rxaf_chk i_rxaf_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .byte_valid     (byte_valid),
    .mode_cfg       (mode_cfg),
    .frame_last     (addr_last),
    .dst_addr       (addr_now),
    .stn_addr       (stn_addr),
    .verdict_valid  (verdict_valid),
    .verdict_accept (verdict_accept)
);

// File: tb/test_rx_dest_filter.sv
module test_rx_dest_filter;
    typedef logic [5:0][7:0] addr_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bv = 1'b0, bs = 1'b0;
    logic [7:0]  bd = 8'h00;
    logic [3:0]  mode = 4'h0;
    logic [15:0] w0 = 16'h0, w1 = 16'h0, w2 = 16'h0;
    logic [31:0] tlo = 32'h0, thi = 32'h0;
    logic        dut_v, dut_a;

    int    total = 0, bad = 0;
    string cur_req = "R10";
    bit    done = 0;

    // model state
    int    m_cnt = 0;
    addr_t m_buf;
    logic  exp_v = 1'b0, exp_a = 1'b0;

    always #10 clk = ~clk;

    rx_dest_filter i_rx_dest_filter (
        .clk(clk), .rst_n(rst_n), .byte_valid(bv), .byte_sof(bs),
        .byte_data(bd), .mode_cfg(mode), .station_w0(w0), .station_w1(w1),
        .station_w2(w2), .hash_lo(tlo), .hash_hi(thi),
        .verdict_valid(dut_v), .verdict_accept(dut_a));

    function automatic int ref_index(addr_t a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < 6; i++)
            for (int b = 0; b < 8; b++) begin
                logic top = c[31];
                c = c << 1;
                if (top != a[i][b]) c = c ^ 32'h04C11DB7;
            end
        return int'((c >> 23) & 32'h3F);
    endfunction

    function automatic logic ref_accept(addr_t a);
        addr_t st;
        int k;
        st[0] = w2[7:0]; st[1] = w2[15:8];
        st[2] = w1[7:0]; st[3] = w1[15:8];
        st[4] = w0[7:0]; st[5] = w0[15:8];
        if (mode[3]) return 1'b1;
        if (a == 48'hFFFFFFFFFFFF) return mode[0];
        if (a[0][0]) begin
            if (mode[2]) return 1'b1;
            if (!mode[1]) return 1'b0;
            k = ref_index(a);
            return (k >= 32) ? thi[k-32] : tlo[k];
        end
        return a == st;
    endfunction

    task automatic step(input logic v, input logic s, input logic [7:0] d);
        bit fin = 0;
        @(negedge clk);
        total++;
        if (dut_v !== exp_v || dut_a !== exp_a) begin
            bad++;
            $display("FAIL %s: valid/accept actual %b/%b expected %b/%b at %0t",
                     cur_req, dut_v, dut_a, exp_v, exp_a, $time);
        end
        bv = v; bs = s; bd = d;
        if (!rst_n) begin
            m_cnt = 0;
        end else if (v && s) begin
            m_buf[0] = d; m_cnt = 1;
        end else if (v && m_cnt >= 1 && m_cnt < 6) begin
            m_buf[m_cnt] = d; m_cnt++;
            if (m_cnt == 6) fin = 1;
        end
        exp_v = fin && rst_n;
        exp_a = exp_v ? ref_accept(m_buf) : 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00);
    endtask

    task automatic send(input addr_t a, input int gap);
        for (int i = 0; i < 6; i++) begin
            step(1'b1, i == 0, a[i]);
            if (i < 5) idle(gap);
        end
        idle(2);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        addr_t stn, a, g_lo, g_hi;
        int k_lo, k_hi;
        bit got_lo, got_hi;
        // station 02:11:22:33:44:55
        stn = {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02};
        w2 = 16'h1102; w1 = 16'h3322; w0 = 16'h5544;

        // R10: reset state, also with traffic during reset
        cur_req = "R10";
        idle(3);
        step(1'b1, 1'b1, 8'h02);
        idle(2);
        rst_n = 1'b1;
        idle(2);

        // R1: bytes without start marker ignored, even in promiscuous mode
        cur_req = "R1"; mode = 4'b1000;
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 8'(i));
        idle(2);

        // R9: exact unicast match, misses in last and first byte
        cur_req = "R9"; mode = 4'b0000;
        send(stn, 0);
        a = stn; a[5][0] = ~a[5][0]; send(a, 0);
        a = stn; a[0][1] = ~a[0][1]; send(a, 1);
        mode = 4'b0111; send(stn, 0);
        a = stn; a[3] = 8'h00; send(a, 0);

        // R5: broadcast governed by bit 0 only
        cur_req = "R5";
        a = 48'hFFFFFFFFFFFF;
        mode = 4'b0001; send(a, 0);
        mode = 4'b0110; tlo = '1; thi = '1; send(a, 0);
        mode = 4'b0000; send(a, 2);

        // R4: promiscuous
        cur_req = "R4"; mode = 4'b1000; tlo = '0; thi = '0;
        send(a, 0);
        send({8'h9A, 8'h88, 8'h77, 8'h66, 8'h55, 8'h04}, 0);
        send({8'h00, 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01}, 0);

        // R6: all group
        cur_req = "R6"; mode = 4'b0100;
        send({8'h01, 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01}, 0);
        send({8'hAB, 8'hCD, 8'hEF, 8'h12, 8'h34, 8'h33}, 1);

        // R7: hashed group, one address per table word
        cur_req = "R7"; mode = 4'b0010;
        got_lo = 0; got_hi = 0; k_lo = 0; k_hi = 0;
        for (int k = 0; k < 256; k++) begin
            a = {8'(k), 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
            if (ref_index(a) < 32 && !got_lo) begin g_lo = a; k_lo = ref_index(a); got_lo = 1; end
            if (ref_index(a) >= 32 && !got_hi) begin g_hi = a; k_hi = ref_index(a); got_hi = 1; end
        end
        tlo = 32'h1 << k_lo; thi = '0; send(g_lo, 0);
        tlo = ~(32'h1 << k_lo); thi = '1; send(g_lo, 0);
        tlo = '0; thi = 32'h1 << (k_hi - 32); send(g_hi, 0);
        tlo = '1; thi = ~(32'h1 << (k_hi - 32)); send(g_hi, 1);

        // R8: group rejected with hash and all-group off
        cur_req = "R8"; mode = 4'b0001; tlo = '1; thi = '1;
        send(g_lo, 0);
        send(g_hi, 0);

        // R3: trailing bytes, restart mid-address, back-to-back
        cur_req = "R3"; mode = 4'b0000; tlo = '0; thi = '0;
        for (int i = 0; i < 10; i++) step(1'b1, i == 0, (i < 6) ? stn[i] : 8'hEE);
        idle(2);
        a = stn; a[2] = 8'h99;
        for (int i = 0; i < 3; i++) step(1'b1, i == 0, a[i]);
        for (int i = 0; i < 6; i++) step(1'b1, i == 0, stn[i]);
        for (int i = 0; i < 6; i++) step(1'b1, i == 0, a[i]);
        for (int i = 0; i < 6; i++) step(1'b1, i == 0, stn[i]);
        idle(3);

        // R11: configuration change right after the sixth byte
        cur_req = "R11"; mode = 4'b0000;
        a = 48'hFFFFFFFFFFFF;
        for (int i = 0; i < 6; i++) step(1'b1, i == 0, a[i]);
        mode = 4'b0001;
        idle(2);
        for (int i = 0; i < 6; i++) step(1'b1, i == 0, stn[i]);
        w2 = 16'h0000;
        idle(2);
        w2 = 16'h1102;

        // R2 / R10: reset mid-address discards it
        cur_req = "R10";
        for (int i = 0; i < 3; i++) step(1'b1, i == 0, stn[i]);
        rst_n = 1'b0; idle(1); rst_n = 1'b1;
        cur_req = "R2";
        for (int i = 3; i < 6; i++) step(1'b1, 1'b0, stn[i]);
        idle(2);
        send(stn, 3);

        done = 1;
        summary();
        $finish;
    end
endmodule